// File: doc/BRIEF.md
# Multi-Master I2C Byte Controller

This block runs the master side of an I2C bus, one byte at a time, on a bus that other masters may also use. It starts in slave mode with both bus lines released. When software asks for a START and the bus is idle, the block forms the START, takes the bus and enters master mode. Software then hands it bytes to transmit or to receive. For each byte the block clocks out or samples eight data bits, most significant bit first, followed by a ninth acknowledge pulse. When software asks for a STOP, the block forms it and goes back to slave mode.

While it transmits, the block compares every bit it released high with the level on the bus. If another master holds SDA low, the block stops driving at once, raises an arbitration-lost flag and returns to slave mode. A bus monitor watches every START and STOP on the lines, including those from other masters, and keeps a bus-busy flag from them. The SCL period comes from a prescale counter on the system clock. High and low phases are equal in length, and a configuration bit chooses the standard or the fast half-period.

Both lines are open drain. The outputs `scl_oe` and `sda_oe` pull a line low when set, and `scl_in` and `sda_in` carry the wired level that results.

Top module: `i2c_mm_ctrl`

## Requirements
- R1: After reset the block is in slave mode (`is_master`=0), with `scl_oe`=0 and `sda_oe`=0, and `arb_lost`, `byte_done` and `bus_busy` all 0.
- R2: A START is formed only when `start_req` is seen while the block is idle and `bus_busy`=0. SDA is pulled low while SCL is high, and one half-period later SCL is pulled low. At that point `is_master` and `start_sent` become 1. A `start_req` seen while `bus_busy`=1 is ignored and leaves both lines released.
- R3: A `stop_req` seen while the block is master and waiting between bytes forms a STOP: SDA goes low with SCL low, SCL is released, and one half-period later SDA is released. `is_master` falls in that same cycle.
- R4: A transmitted byte (`byte_dir_tx`=1) appears on SDA most significant bit first, one bit per SCL high phase. On the ninth pulse the block releases SDA and samples it into `ack_in` (0 = acknowledged, 1 = not acknowledged). `byte_done` pulses high for exactly one cycle, in the cycle after SCL falls at the end of the ninth pulse.
- R5: A received byte (`byte_dir_tx`=0) is sampled from SDA, most significant bit first, at the end of each SCL high phase and appears on `rx_byte`. On the ninth pulse the block pulls SDA low if `ack_out` was 1 when the byte was started, and leaves it released otherwise.
- R6: During a transmitted bit in which the block leaves SDA released, if SDA reads low while SCL is high, the block sets `arb_lost` in the next cycle. In that same cycle it releases both lines and drops `is_master`. `arb_lost` stays set until the next START the block forms.
- R7: Each SCL high phase lasts `STD_HALF` system clocks when `cfg_fast`=0 and `FAST_HALF` system clocks when `cfg_fast`=1.
- R8: `bus_busy` rises one cycle after any START on the bus (SDA falling while SCL stays high) and falls one cycle after any STOP (SDA rising while SCL stays high), whether or not this block formed it.
- R9: While the block is master, its SDA output changes only in cycles where SCL was pulled low both before and after the change. The only exceptions are the SDA edges that form START and STOP.
- R10: `byte_go` is accepted only while the block is master and waiting between bytes. `is_tx` then holds the direction of the byte in progress (1 = transmit), and a `byte_go` at any other time changes neither `is_tx` nor the byte on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fast | input | 1 | 1 selects the fast SCL half-period |
| start_req | input | 1 | Request to form a START and take the bus |
| stop_req | input | 1 | Request to form a STOP and release the bus |
| byte_go | input | 1 | Start the next byte transfer |
| byte_dir_tx | input | 1 | Direction of the next byte: 1 transmit, 0 receive |
| tx_byte | input | 8 | Byte to transmit |
| ack_out | input | 1 | 1 to acknowledge a received byte |
| scl_in | input | 1 | Wired SCL level on the bus |
| sda_in | input | 1 | Wired SDA level on the bus |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| is_master | output | 1 | Block currently owns the bus |
| bus_busy | output | 1 | A START has been seen with no STOP after it |
| arb_lost | output | 1 | Arbitration was lost during the last transfer |
| byte_done | output | 1 | One-cycle pulse at the end of a byte and its acknowledge |
| is_tx | output | 1 | Direction of the current or last byte |
| start_sent | output | 1 | A START was formed and no byte has started since |
| ack_in | output | 1 | SDA level sampled on the ninth pulse |
| rx_byte | output | 8 | Byte sampled from the bus |

## Verification
The bench goes after arbitration loss by pulling SDA low in the low phase ahead of a bit the block sends as 1. A design that checked only at the end of the high phase, or that kept SCL pulled low, would still be master when the flag rises. A bench model of START and STOP detection is compared with `bus_busy` on every clock, and that includes conditions made by another master. A design that cleared busy on its own STOP only, or that set it a cycle late, shows up there. Every clock with SCL high in master mode is checked for an SDA edge. A design that moved SDA on the same edge where SCL falls would break this. The high phase is measured in both rates, and a `byte_go` pulse is sent in the middle of a byte to catch a direction register that takes commands outside the wait state.

// File: rtl/i2c_mm_pkg.sv
package i2c_mm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_STOP_LO,
    ST_STOP_HI
  } mm_state_t;

  // half-period length in system clocks for the selected rate
  function automatic int unsigned half_len(input logic fast,
                                           input int unsigned std_h,
                                           input int unsigned fast_h);
    return fast ? fast_h : std_h;
  endfunction

  // states that last a timed half-period
  function automatic logic is_timed(input mm_state_t s);
    return !(s == ST_IDLE || s == ST_WAIT);
  endfunction

endpackage

// File: rtl/i2c_mm_phase_timer.sv
module i2c_mm_phase_timer #(
  parameter int unsigned STD_HALF  = 16,
  parameter int unsigned FAST_HALF = 4,
  localparam int unsigned MAXH = (STD_HALF > FAST_HALF) ? STD_HALF : FAST_HALF,
  localparam int unsigned CW   = $clog2(MAXH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  import i2c_mm_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload = CW'(half_len(fast, STD_HALF, FAST_HALF) - 1);
  assign tick   = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= reload;
    else if (tick)     cnt_q <= reload;
    else               cnt_q <= cnt_q - 1'b1;
  end

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt_q == $past(reload))); // R7

endmodule

// File: rtl/i2c_mm_bus_watch.sv
module i2c_mm_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_q, sda_q;
  logic start_ev, stop_ev;

  assign start_ev = scl_q && scl_in && sda_q && !sda_in;
  assign stop_ev  = scl_q && scl_in && !sda_q && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_ev)     busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy); // R8
  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !busy); // R8

endmodule

// File: rtl/i2c_mm_ctrl.sv
module i2c_mm_ctrl #(
  parameter int unsigned STD_HALF  = 16,
  parameter int unsigned FAST_HALF = 4,
  parameter int unsigned DW        = 8,
  localparam int unsigned BW       = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fast,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          byte_go,
  input  logic          byte_dir_tx,
  input  logic [DW-1:0] tx_byte,
  input  logic          ack_out,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          is_master,
  output logic          bus_busy,
  output logic          arb_lost,
  output logic          byte_done,
  output logic          is_tx,
  output logic          start_sent,
  output logic          ack_in,
  output logic [DW-1:0] rx_byte
);
  import i2c_mm_pkg::*;

  mm_state_t     state_q;
  logic          scl_oe_q, sda_oe_q, master_q, arb_q, done_q;
  logic          tx_q, sent_q, ack_in_q, ackdrv_q;
  logic [DW-1:0] sh_q;
  logic [BW-1:0] bit_q;

  // named internal events
  logic tick, run, arb_hit, start_go, byte_take, stop_take, last_bit;

  assign run       = is_timed(state_q);
  assign start_go  = (state_q == ST_IDLE) && start_req && !bus_busy;
  assign byte_take = (state_q == ST_WAIT) && byte_go;
  assign stop_take = (state_q == ST_WAIT) && !byte_go && stop_req;
  assign last_bit  = (bit_q == '0);
  assign arb_hit   = (state_q == ST_BIT_HI) && tx_q && !sda_oe_q && scl_in && !sda_in;

  i2c_mm_phase_timer #(.STD_HALF(STD_HALF), .FAST_HALF(FAST_HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .fast(cfg_fast), .tick(tick)
  );

  i2c_mm_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(bus_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      master_q <= 1'b0;
      arb_q    <= 1'b0;
      done_q   <= 1'b0;
      tx_q     <= 1'b0;
      sent_q   <= 1'b0;
      ack_in_q <= 1'b0;
      ackdrv_q <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_go) begin
            state_q  <= ST_START;
            sda_oe_q <= 1'b1;
            arb_q    <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            state_q  <= ST_WAIT;
            scl_oe_q <= 1'b1;
            master_q <= 1'b1;
            sent_q   <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (byte_take) begin
            sh_q     <= tx_byte;
            tx_q     <= byte_dir_tx;
            ackdrv_q <= ack_out;
            bit_q    <= BW'(DW - 1);
            sent_q   <= 1'b0;
            state_q  <= ST_BIT_LO;
          end else if (stop_take) begin
            state_q <= ST_STOP_LO;
          end
        end
        ST_BIT_LO: begin
          sda_oe_q <= tx_q && !sh_q[DW-1];
          if (tick) begin
            state_q  <= ST_BIT_HI;
            scl_oe_q <= 1'b0;
          end
        end
        ST_BIT_HI: begin
          if (arb_hit) begin
            state_q  <= ST_IDLE;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            master_q <= 1'b0;
            arb_q    <= 1'b1;
          end else if (tick) begin
            scl_oe_q <= 1'b1;
            sh_q     <= {sh_q[DW-2:0], sda_in};
            if (last_bit) begin
              state_q <= ST_ACK_LO;
            end else begin
              bit_q   <= bit_q - 1'b1;
              state_q <= ST_BIT_LO;
            end
          end
        end
        ST_ACK_LO: begin
          sda_oe_q <= !tx_q && ackdrv_q;
          if (tick) begin
            state_q  <= ST_ACK_HI;
            scl_oe_q <= 1'b0;
          end
        end
        ST_ACK_HI: begin
          if (tick) begin
            ack_in_q <= sda_in;
            done_q   <= 1'b1;
            scl_oe_q <= 1'b1;
            state_q  <= ST_WAIT;
          end
        end
        ST_STOP_LO: begin
          sda_oe_q <= 1'b1;
          if (tick) begin
            state_q  <= ST_STOP_HI;
            scl_oe_q <= 1'b0;
          end
        end
        ST_STOP_HI: begin
          if (tick) begin
            sda_oe_q <= 1'b0;
            master_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe     = scl_oe_q;
  assign sda_oe     = sda_oe_q;
  assign is_master  = master_q;
  assign arb_lost   = arb_q;
  assign byte_done  = done_q;
  assign is_tx      = tx_q;
  assign start_sent = sent_q;
  assign ack_in     = ack_in_q;
  assign rx_byte    = sh_q;

  AST_MASTER_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_q) |-> ($past(state_q) == ST_START)); // R2
  AST_SLAVE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_q) |-> (arb_q || state_q == ST_IDLE)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit |=> (arb_q && !master_q && !scl_oe_q && !sda_oe_q)); // R6
  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && (sda_oe_q != $past(sda_oe_q))) |-> (scl_oe_q && $past(scl_oe_q))); // R9
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && state_q != ST_WAIT) |=> $stable(tx_q)); // R10

endmodule

// File: tb/sim_i2c_mm_ctrl.sv
module sim_i2c_mm_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int STD_H  = 16;
  localparam int FAST_H = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_fast, start_req, stop_req, byte_go, byte_dir_tx, ack_out;
  logic [7:0] tx_byte, rx_byte;
  logic scl_oe, sda_oe, is_master, bus_busy, arb_lost, byte_done, is_tx, start_sent, ack_in;
  logic ext_scl_low, ext_sda_low;
  logic scl_w, sda_w;

  assign scl_w = !(scl_oe || ext_scl_low);
  assign sda_w = !(sda_oe || ext_sda_low);

  i2c_mm_ctrl #(.STD_HALF(STD_H), .FAST_HALF(FAST_H)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .start_req(start_req),
    .stop_req(stop_req), .byte_go(byte_go), .byte_dir_tx(byte_dir_tx),
    .tx_byte(tx_byte), .ack_out(ack_out), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .is_master(is_master), .bus_busy(bus_busy),
    .arb_lost(arb_lost), .byte_done(byte_done), .is_tx(is_tx),
    .start_sent(start_sent), .ack_in(ack_in), .rx_byte(rx_byte)
  );

  int total = 0;
  int bad   = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // reference model of the bus, compared on every clock
  logic pm_scl = 1'b1, pm_sda = 1'b1, busy_m = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pm_scl = 1'b1; pm_sda = 1'b1; busy_m = 1'b0;
    end else begin
      check_eq("R8", "bus_busy vs model", int'(bus_busy), int'(busy_m));
      if (is_master && pm_scl && scl_w)
        check_eq("R9", "SDA edge with SCL high", int'(sda_w), int'(pm_sda));
      if (pm_scl && scl_w && pm_sda && !sda_w)      busy_m = 1'b1;
      else if (pm_scl && scl_w && !pm_sda && sda_w) busy_m = 1'b0;
      pm_scl = scl_w;
      pm_sda = sda_w;
    end
  end

  task automatic hi_phase(output int len);
    len = 0;
    while (scl_w) begin
      @(posedge clk); #1;
      len++;
    end
  endtask

  task automatic do_start();
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
    wait (is_master == 1'b1); #1;
    check_eq("R2", "start_sent", int'(start_sent), 1);
    check_eq("R2", "SDA low after start", int'(sda_w), 0);
    check_eq("R2", "SCL low after start", int'(scl_w), 0);
    check_eq("R6", "arb_lost cleared by start", int'(arb_lost), 0);
    wait_clk(2);
    check_eq("R8", "busy after own start", int'(bus_busy), 1);
  endtask

  task automatic do_stop();
    @(posedge clk); #1 stop_req = 1'b1;
    @(posedge clk); #1 stop_req = 1'b0;
    wait (is_master == 1'b0); #1;
    check_eq("R3", "SCL released after stop", int'(scl_w), 1);
    check_eq("R3", "SDA released after stop", int'(sda_w), 1);
    wait_clk(3);
    check_eq("R3", "busy cleared after stop", int'(bus_busy), 0);
  endtask

  task automatic send_tx(input logic [7:0] d, input bit slave_ack, input int exp_hi);
    logic [7:0] seen;
    int hi;
    byte_dir_tx = 1'b1; tx_byte = d;
    @(posedge clk); #1 byte_go = 1'b1;
    @(posedge clk); #1 byte_go = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_w); #1;
      seen[7-i] = sda_w;
      hi_phase(hi);
      if (i == 0) begin
        // a byte_go in the middle of a byte must be ignored
        @(posedge clk); #1 byte_dir_tx = 1'b0; byte_go = 1'b1;
        @(posedge clk); #1 byte_go = 1'b0; byte_dir_tx = 1'b1;
        check_eq("R10", "is_tx kept during byte", int'(is_tx), 1);
      end
    end
    check_eq("R7", "SCL high phase length", hi, exp_hi);
    check_eq("R4", "byte sent MSB first", int'(seen), int'(d));
    ext_sda_low = slave_ack;
    @(posedge scl_w); #1;
    hi_phase(hi);
    ext_sda_low = 1'b0;
    check_eq("R4", "byte_done after ninth pulse", int'(byte_done), 1);
    check_eq("R4", "ack_in sampled", int'(ack_in), slave_ack ? 0 : 1);
    wait_clk(1);
    check_eq("R4", "byte_done one cycle", int'(byte_done), 0);
  endtask

  task automatic recv(input logic [7:0] d, input bit give_ack);
    byte_dir_tx = 1'b0; ack_out = give_ack;
    ext_sda_low = !d[7];
    @(posedge clk); #1 byte_go = 1'b1;
    @(posedge clk); #1 byte_go = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_w); #1;
      while (scl_w) begin @(posedge clk); #1; end
      ext_sda_low = (i < 7) ? !d[6-i] : 1'b0;
    end
    @(posedge scl_w); #1;
    check_eq("R5", "ack driven on ninth pulse", int'(sda_w), give_ack ? 0 : 1);
    while (scl_w) begin @(posedge clk); #1; end
    check_eq("R5", "rx_byte", int'(rx_byte), int'(d));
    check_eq("R4", "byte_done after receive", int'(byte_done), 1);
    check_eq("R10", "is_tx for receive", int'(is_tx), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired, run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_fast = 1'b0; start_req = 1'b0; stop_req = 1'b0;
    byte_go = 1'b0; byte_dir_tx = 1'b0; tx_byte = 8'h00; ack_out = 1'b0;
    ext_scl_low = 1'b0; ext_sda_low = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(1);
    // R1 reset state
    check_eq("R1", "is_master", int'(is_master), 0);
    check_eq("R1", "scl_oe", int'(scl_oe), 0);
    check_eq("R1", "sda_oe", int'(sda_oe), 0);
    check_eq("R1", "arb_lost", int'(arb_lost), 0);
    check_eq("R1", "byte_done", int'(byte_done), 0);
    check_eq("R1", "bus_busy", int'(bus_busy), 0);

    // R2 nothing happens without a request
    wait_clk(40);
    check_eq("R2", "no master without request", int'(is_master), 0);
    check_eq("R2", "lines idle without request", int'(scl_w && sda_w), 1);

    // standard rate traffic
    do_start();
    send_tx(8'hA5, 1'b1, STD_H);
    send_tx(8'h3C, 1'b0, STD_H);
    recv(8'h96, 1'b1);
    do_stop();

    // fast rate traffic
    cfg_fast = 1'b1;
    do_start();
    send_tx(8'h5A, 1'b1, FAST_H);
    recv(8'h0F, 1'b0);
    do_stop();

    // R6 arbitration loss on the third bit of 0xFF
    cfg_fast = 1'b0;
    do_start();
    byte_dir_tx = 1'b1; tx_byte = 8'hFF;
    @(posedge clk); #1 byte_go = 1'b1;
    @(posedge clk); #1 byte_go = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(posedge scl_w); #1;
      while (scl_w) begin @(posedge clk); #1; end
    end
    ext_sda_low = 1'b1;
    wait (arb_lost == 1'b1); #1;
    check_eq("R6", "master dropped on loss", int'(is_master), 0);
    check_eq("R6", "scl released on loss", int'(scl_oe), 0);
    check_eq("R6", "sda released on loss", int'(sda_oe), 0);
    check_eq("R6", "SCL high right after loss", int'(scl_w), 1);
    wait_clk(3);
    check_eq("R8", "busy held while other master owns bus", int'(bus_busy), 1);
    ext_sda_low = 1'b0;
    wait_clk(3);
    check_eq("R8", "busy cleared by foreign stop", int'(bus_busy), 0);
    check_eq("R6", "arb_lost sticky", int'(arb_lost), 1);

    // R8 foreign START, and R2 request ignored while busy
    wait_clk(5);
    ext_sda_low = 1'b1;
    wait_clk(3);
    check_eq("R8", "busy after foreign start", int'(bus_busy), 1);
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
    wait_clk(40);
    check_eq("R2", "start ignored while busy", int'(is_master), 0);
    check_eq("R2", "scl untouched while busy", int'(scl_oe), 0);
    check_eq("R2", "sda untouched while busy", int'(sda_oe), 0);
    ext_sda_low = 1'b0;
    wait_clk(3);
    check_eq("R8", "busy cleared after foreign stop", int'(bus_busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule